// File: doc/BRIEF.md
# Transmit Descriptor Ring Sequencer

This block is the control half of a transmit DMA that walks a ring of descriptors kept in memory. Software fills a descriptor (a status word, a control word carrying length and segment flags, and a buffer pointer), hands it to hardware by setting bit 31 of the status word, and then strobes a poll input. The sequencer reads the descriptor at its current ring position, asks the MAC to send the buffer, waits for the MAC to report completion, and writes the status word back with ownership returned to software. It then moves on to the next descriptor and keeps going until it meets one that software still owns.

Descriptors are 16 bytes apart starting at a 16-byte aligned base address. A flag in the control word marks the last descriptor in the ring; after finishing it the sequencer continues at the base again. Lengths outside the legal range are refused without a send, and short frames are padded up to the minimum length on the request to the MAC. Moving the frame bytes and the MAC itself sit outside this block.

Top module: `txring_seq`

## Requirements
- R1: After reset, and until the first poll strobe, the block raises neither the memory request nor the send request.
- R2: A poll strobe while idle starts a read of the status word (byte offset 0) of the descriptor at the current ring position; after reset that position is the base address.
- R3: When status bit 31 reads 1, the block reads the control word (offset 4) and the buffer word (offset 8), then requests a send carrying the buffer word, the length from control bits [10:0], first-segment from control bit 30 and last-segment from control bit 29. The memory request and the send request are never active together.
- R4: A length from 1 to 59 is requested as 60; a length from 60 to 1536 is requested unchanged.
- R5: A length of 0 or above 1536 produces no send; the status word is written back as 0x0000_0002.
- R6: For a legal length the status word is written back as 0x0000_0000, and only after the MAC has signalled send-done.
- R7: After a write-back the block reads the next descriptor, 16 bytes further on, without waiting for another poll.
- R8: When control bit 31 (end of ring) is set, the descriptor following the write-back is read at the base address.
- R9: A status word with bit 31 clear ends processing: nothing is written to that descriptor, the position is kept, and the next poll reads the same descriptor again.
- R10: A poll strobe that arrives while the block is busy, including in the very cycle a software-owned status word is returned, causes one further read of the status word at the stopping position.
- R11: A memory request keeps its address and direction until acknowledged, and a send request keeps its address and length until send-done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poll_i | input | 1 | One-cycle poll strobe |
| base_addr_i | input | AW | Ring base address, 16-byte aligned |
| dm_req_o | output | 1 | Descriptor memory request |
| dm_we_o | output | 1 | 1 for write, 0 for read |
| dm_addr_o | output | AW | Byte address of the word accessed |
| dm_wdata_o | output | 32 | Write data |
| dm_rdata_i | input | 32 | Read data, valid with acknowledge |
| dm_ack_i | input | 1 | Memory acknowledge, one cycle |
| snd_req_o | output | 1 | Frame send request to the MAC |
| snd_addr_o | output | AW | Buffer address of the frame |
| snd_len_o | output | LEN_W | Frame length in bytes after padding |
| snd_first_o | output | 1 | First-segment flag |
| snd_last_o | output | 1 | Last-segment flag |
| snd_done_i | input | 1 | One-cycle send completion |

## Verification
Two functions can land in one cycle: the arrival of a poll strobe and the return of a status word showing software ownership, which would otherwise send the block idle. The bench watches the memory acknowledge of a status read on a software-owned descriptor and drives the poll in exactly that cycle, then counts the reads of that status word, expecting two rather than one. A related case drives the poll during a send on a one-descriptor ring and expects a third status read after the wrap.

// File: rtl/txring_pkg.sv
package txring_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_STAT,
    ST_RD_CTRL,
    ST_RD_BUF,
    ST_SEND,
    ST_WRBACK
  } txr_state_e;

  // status word
  localparam int unsigned HW_OWN_BIT = 31;
  localparam int unsigned BAD_LEN_BIT = 1;
  // control word
  localparam int unsigned RING_END_BIT = 31;
  localparam int unsigned SEG_FIRST_BIT = 30;
  localparam int unsigned SEG_LAST_BIT = 29;

  // word selectors inside one descriptor
  localparam logic [1:0] WSEL_STAT = 2'd0;
  localparam logic [1:0] WSEL_CTRL = 2'd1;
  localparam logic [1:0] WSEL_BUF  = 2'd2;

  localparam int unsigned DESC_SHIFT = 4;

endpackage

// File: rtl/txring_rst_sync.sv
module txring_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/txring_ctrl_dec.sv
module txring_ctrl_dec #(
  parameter int unsigned LEN_W   = 11,
  parameter int unsigned MIN_LEN = 60,
  parameter int unsigned MAX_LEN = 1536
) (
  input  logic [31:0]      ctrl_word,
  output logic             ring_end,
  output logic             seg_first,
  output logic             seg_last,
  output logic             len_bad,
  output logic [LEN_W-1:0] len_pad
);
  import txring_pkg::*;

  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

  logic [LEN_W-1:0] len_raw;

  always_comb begin
    len_raw   = ctrl_word[LEN_W-1:0];
    ring_end  = ctrl_word[RING_END_BIT];
    seg_first = ctrl_word[SEG_FIRST_BIT];
    seg_last  = ctrl_word[SEG_LAST_BIT];
    len_bad   = (len_raw == '0) || (len_raw > MAX_L);
    len_pad   = (len_raw < MIN_L) ? MIN_L : len_raw;
  end
endmodule

// File: rtl/txring_ptr.sv
module txring_ptr #(
  parameter int unsigned AW    = 32,
  parameter int unsigned IDX_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          wrap,
  input  logic [1:0]    wsel,
  input  logic [AW-1:0] base_addr,
  output logic [AW-1:0] word_addr
);
  import txring_pkg::*;

  logic [IDX_W-1:0] idx_q, idx_n;
  logic             idx_en;

  always_comb begin
    idx_en = step;
    idx_n  = wrap ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_n;
  end

  always_comb begin
    word_addr = base_addr + (AW'(idx_q) << DESC_SHIFT) + (AW'(wsel) << 2);
  end
endmodule

// File: rtl/txring_fsm.sv
module txring_fsm #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          poll,
  input  logic          dm_ack,
  input  logic [31:0]   dm_rdata,
  input  logic          snd_done,
  input  logic          len_bad,
  input  logic          ring_end,
  output logic          dm_req,
  output logic          dm_we,
  output logic [1:0]    wsel,
  output logic [31:0]   dm_wdata,
  output logic          step,
  output logic          wrap,
  output logic          snd_req,
  output logic [AW-1:0] buf_q,
  output logic [31:0]   ctrl_q
);
  import txring_pkg::*;

  txr_state_e state_q, state_n;
  logic       pend_q, pend_n;
  logic       cap_ctrl, cap_buf;

  always_comb begin
    state_n  = state_q;
    pend_n   = pend_q | (poll && (state_q != ST_IDLE));
    cap_ctrl = 1'b0;
    cap_buf  = 1'b0;
    step     = 1'b0;
    wrap     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (poll) state_n = ST_RD_STAT;
      end
      ST_RD_STAT: begin
        if (dm_ack) begin
          pend_n = 1'b0;
          if (dm_rdata[HW_OWN_BIT])   state_n = ST_RD_CTRL;
          else if (pend_q || poll)    state_n = ST_RD_STAT;
          else                        state_n = ST_IDLE;
        end
      end
      ST_RD_CTRL: begin
        if (dm_ack) begin
          cap_ctrl = 1'b1;
          state_n  = ST_RD_BUF;
        end
      end
      ST_RD_BUF: begin
        if (dm_ack) begin
          cap_buf = 1'b1;
          state_n = len_bad ? ST_WRBACK : ST_SEND;
        end
      end
      ST_SEND: begin
        if (snd_done) state_n = ST_WRBACK;
      end
      ST_WRBACK: begin
        if (dm_ack) begin
          step    = 1'b1;
          wrap    = ring_end;
          state_n = ST_RD_STAT;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      pend_q  <= pend_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl_q <= '0;
    else if (cap_ctrl) ctrl_q <= dm_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       buf_q <= '0;
    else if (cap_buf) buf_q <= AW'(dm_rdata);
  end

  always_comb begin
    dm_req   = (state_q == ST_RD_STAT) || (state_q == ST_RD_CTRL) ||
               (state_q == ST_RD_BUF)  || (state_q == ST_WRBACK);
    dm_we    = (state_q == ST_WRBACK);
    snd_req  = (state_q == ST_SEND);
    dm_wdata = '0;
    if (len_bad) dm_wdata[BAD_LEN_BIT] = 1'b1;
    unique case (state_q)
      ST_RD_CTRL: wsel = WSEL_CTRL;
      ST_RD_BUF:  wsel = WSEL_BUF;
      default:    wsel = WSEL_STAT;
    endcase
  end
endmodule

// File: rtl/txring_seq.sv
module txring_seq #(
  parameter int unsigned AW      = 32,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned LEN_W   = 11,
  parameter int unsigned MIN_LEN = 60,
  parameter int unsigned MAX_LEN = 1536
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             poll_i,
  input  logic [AW-1:0]    base_addr_i,
  output logic             dm_req_o,
  output logic             dm_we_o,
  output logic [AW-1:0]    dm_addr_o,
  output logic [31:0]      dm_wdata_o,
  input  logic [31:0]      dm_rdata_i,
  input  logic             dm_ack_i,
  output logic             snd_req_o,
  output logic [AW-1:0]    snd_addr_o,
  output logic [LEN_W-1:0] snd_len_o,
  output logic             snd_first_o,
  output logic             snd_last_o,
  input  logic             snd_done_i
);
  logic        rst_sync_n;
  logic        step, wrap, len_bad, ring_end;
  logic [1:0]  wsel;
  logic [31:0] ctrl_q;

  txring_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  txring_fsm #(.AW(AW)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .poll     (poll_i),
    .dm_ack   (dm_ack_i),
    .dm_rdata (dm_rdata_i),
    .snd_done (snd_done_i),
    .len_bad  (len_bad),
    .ring_end (ring_end),
    .dm_req   (dm_req_o),
    .dm_we    (dm_we_o),
    .wsel     (wsel),
    .dm_wdata (dm_wdata_o),
    .step     (step),
    .wrap     (wrap),
    .snd_req  (snd_req_o),
    .buf_q    (snd_addr_o),
    .ctrl_q   (ctrl_q)
  );

  txring_ctrl_dec #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_dec (
    .ctrl_word (ctrl_q),
    .ring_end  (ring_end),
    .seg_first (snd_first_o),
    .seg_last  (snd_last_o),
    .len_bad   (len_bad),
    .len_pad   (snd_len_o)
  );

  txring_ptr #(.AW(AW), .IDX_W(IDX_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .step      (step),
    .wrap      (wrap),
    .wsel      (wsel),
    .base_addr (base_addr_i),
    .word_addr (dm_addr_o)
  );
endmodule

// File: rtl/txring_chk.sv
module txring_chk #(
  parameter int unsigned AW      = 32,
  parameter int unsigned LEN_W   = 11,
  parameter int unsigned MIN_LEN = 60,
  parameter int unsigned MAX_LEN = 1536
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    base_addr_i,
  input logic             dm_req_o,
  input logic             dm_we_o,
  input logic [AW-1:0]    dm_addr_o,
  input logic [31:0]      dm_wdata_o,
  input logic             dm_ack_i,
  input logic             snd_req_o,
  input logic [AW-1:0]    snd_addr_o,
  input logic [LEN_W-1:0] snd_len_o,
  input logic             snd_done_i
);
  logic [AW-1:0] rel_addr;
  assign rel_addr = dm_addr_o - base_addr_i;

  p_dm_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dm_req_o && !dm_ack_i |=> dm_req_o && $stable(dm_addr_o) && $stable(dm_we_o));

  p_snd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    snd_req_o && !snd_done_i |=> snd_req_o && $stable(snd_addr_o) && $stable(snd_len_o));

  p_len_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    snd_req_o |-> (snd_len_o >= LEN_W'(MIN_LEN)) && (snd_len_o <= LEN_W'(MAX_LEN)));

  p_wb_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dm_req_o && dm_we_o |-> !dm_wdata_o[31] && (rel_addr[3:0] == 4'h0));

  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(dm_req_o && snd_req_o));

  p_wb_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    snd_req_o && snd_done_i |=> dm_req_o && dm_we_o && (dm_wdata_o == 32'h0));
endmodule

bind txring_seq txring_chk #(
  .AW(AW), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .base_addr_i (base_addr_i),
  .dm_req_o    (dm_req_o),
  .dm_we_o     (dm_we_o),
  .dm_addr_o   (dm_addr_o),
  .dm_wdata_o  (dm_wdata_o),
  .dm_ack_i    (dm_ack_i),
  .snd_req_o   (snd_req_o),
  .snd_addr_o  (snd_addr_o),
  .snd_len_o   (snd_len_o),
  .snd_done_i  (snd_done_i)
);

// File: tb/sim_txring_seq.sv
`timescale 1ns/1ps
module sim_txring_seq;
  localparam int AW = 32;
  localparam int LW = 11;
  localparam logic [31:0] BASE = 32'h0000_0100;
  localparam int BW = 64;           // word index of BASE
  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam logic [31:0] EOR = 32'h8000_0000;
  localparam logic [31:0] FS  = 32'h4000_0000;
  localparam logic [31:0] LS  = 32'h2000_0000;

  logic clk = 1'b0;
  logic rst_n;
  logic poll;
  logic dm_req, dm_we, dm_ack;
  logic [AW-1:0] dm_addr;
  logic [31:0] dm_wdata, dm_rdata;
  logic snd_req, snd_first, snd_last, snd_done;
  logic [AW-1:0] snd_addr;
  logic [LW-1:0] snd_len;

  always #5 clk = ~clk;

  txring_seq u0 (
    .clk(clk), .rst_n(rst_n), .poll_i(poll), .base_addr_i(BASE),
    .dm_req_o(dm_req), .dm_we_o(dm_we), .dm_addr_o(dm_addr),
    .dm_wdata_o(dm_wdata), .dm_rdata_i(dm_rdata), .dm_ack_i(dm_ack),
    .snd_req_o(snd_req), .snd_addr_o(snd_addr), .snd_len_o(snd_len),
    .snd_first_o(snd_first), .snd_last_o(snd_last), .snd_done_i(snd_done)
  );

  // ---- memory model
  logic [31:0] mem [0:255];
  int rdcnt [0:255];
  int first_rd_addr;
  int wb_ok, order_bad, n_done;

  always @(posedge clk) begin
    if (!rst_n) begin
      dm_ack <= 1'b0;
      dm_rdata <= '0;
    end else if (dm_req && !dm_ack) begin
      dm_ack <= 1'b1;
      if (dm_we) begin
        mem[dm_addr[9:2]] <= dm_wdata;
        if (dm_wdata == 32'h0) begin
          if (n_done != wb_ok + 1) order_bad++;
          wb_ok++;
        end
      end else begin
        dm_rdata <= mem[dm_addr[9:2]];
        rdcnt[dm_addr[9:2]]++;
        if (first_rd_addr < 0) first_rd_addr = int'(dm_addr);
      end
    end else begin
      dm_ack <= 1'b0;
    end
  end

  // ---- MAC model
  int n_sends;
  int mac_cnt;
  logic [31:0] log_addr [0:31];
  int log_len [0:31];
  logic log_fs [0:31];
  logic log_ls [0:31];

  always @(posedge clk) begin
    if (!rst_n) begin
      snd_done <= 1'b0;
      mac_cnt <= 0;
    end else if (snd_done) begin
      snd_done <= 1'b0;
    end else if (snd_req) begin
      if (mac_cnt == 3) begin
        snd_done <= 1'b1;
        mac_cnt <= 0;
        log_addr[n_sends] = snd_addr;
        log_len[n_sends] = int'(snd_len);
        log_fs[n_sends] = snd_first;
        log_ls[n_sends] = snd_last;
        n_sends++;
        n_done++;
      end else begin
        mac_cnt <= mac_cnt + 1;
      end
    end
  end

  // ---- scoreboard
  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what,
                        input longint act, input longint exp);
    chk(act == exp, req, what, act, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  task automatic do_poll();
    @(negedge clk) poll = 1'b1;
    @(negedge clk) poll = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 12) begin
      @(negedge clk);
      if (dm_req || snd_req || poll) q = 0;
      else q++;
    end
  endtask

  task automatic set_desc(input int k, input logic [31:0] w0,
                          input logic [31:0] w1, input logic [31:0] w2);
    mem[BW + 4*k]     = w0;
    mem[BW + 4*k + 1] = w1;
    mem[BW + 4*k + 2] = w2;
  endtask

  // ---- scenarios
  task automatic t_reset();
    bit seen = 0;
    repeat (20) begin
      @(negedge clk);
      if (dm_req || snd_req) seen = 1;
    end
    chk_eq("R1", "request after reset", seen, 0);
    chk_eq("R1", "send flag after reset", snd_req, 0);
  endtask

  task automatic t_single();
    int s0 = n_sends;
    set_desc(0, OWN, EOR | FS | LS | 32'd100, 32'h1234_5600);
    first_rd_addr = -1;
    do_poll();
    wait_quiet();
    chk_eq("R2", "first read address", first_rd_addr, BASE);
    chk_eq("R3", "send count", n_sends - s0, 1);
    chk_eq("R3", "send address", log_addr[s0], 32'h1234_5600);
    chk_eq("R3", "send length", log_len[s0], 100);
    chk_eq("R3", "first/last flags", {log_fs[s0], log_ls[s0]}, 2'b11);
    chk_eq("R6", "status written back", mem[BW], 0);
    chk_eq("R6", "write-back before done", order_bad, 0);
    chk_eq("R8", "reads of base after wrap", rdcnt[BW], 2);
  endtask

  task automatic t_chain();
    int s0 = n_sends;
    set_desc(0, OWN, FS | 32'd40, 32'hA000_0000);
    set_desc(1, OWN, 32'd60, 32'hA000_1000);
    set_desc(2, OWN, EOR | LS | 32'd1536, 32'hA000_2000);
    do_poll();
    wait_quiet();
    chk_eq("R7", "sends in chain", n_sends - s0, 3);
    chk_eq("R4", "short length padded", log_len[s0], 60);
    chk_eq("R4", "length 60 kept", log_len[s0+1], 60);
    chk_eq("R4", "length 1536 kept", log_len[s0+2], 1536);
    chk_eq("R7", "third buffer address", log_addr[s0+2], 32'hA000_2000);
    chk_eq("R3", "flags desc0", {log_fs[s0], log_ls[s0]}, 2'b10);
    chk_eq("R3", "flags desc1", {log_fs[s0+1], log_ls[s0+1]}, 2'b00);
    chk_eq("R3", "flags desc2", {log_fs[s0+2], log_ls[s0+2]}, 2'b01);
    chk_eq("R6", "desc2 status cleared", mem[BW+8], 0);
    chk_eq("R6", "write-back order", order_bad, 0);
  endtask

  task automatic t_err();
    int s0 = n_sends;
    set_desc(0, OWN, FS | LS | 32'd0, 32'hB000_0000);
    set_desc(1, OWN | 32'h0000_0F00, FS | LS | 32'd1600, 32'hB000_1000);
    set_desc(2, OWN, EOR | FS | LS | 32'd59, 32'hB000_2000);
    do_poll();
    wait_quiet();
    chk_eq("R5", "only legal frame sent", n_sends - s0, 1);
    chk_eq("R5", "zero length status", mem[BW], 32'h2);
    chk_eq("R5", "oversize status", mem[BW+4], 32'h2);
    chk_eq("R4", "59 padded to 60", log_len[s0], 60);
    chk_eq("R4", "sent buffer", log_addr[s0], 32'hB000_2000);
  endtask

  task automatic t_stop();
    int s0 = n_sends;
    int r1;
    set_desc(0, OWN, FS | LS | 32'd300, 32'hC000_0000);
    set_desc(1, 32'h0000_0055, FS | LS | 32'd200, 32'hC000_1000);
    do_poll();
    wait_quiet();
    chk_eq("R9", "stops at software descriptor", n_sends - s0, 1);
    chk_eq("R9", "software status untouched", mem[BW+4], 32'h55);
    r1 = rdcnt[BW+4];
    mem[BW+4] = OWN;
    mem[BW+5] = EOR | FS | LS | 32'd200;
    do_poll();
    wait_quiet();
    chk_eq("R9", "poll resumes at kept position", rdcnt[BW+4] - r1, 1);
    chk_eq("R9", "resumed send address", log_addr[s0+1], 32'hC000_1000);
    chk_eq("R9", "resumed send length", log_len[s0+1], 200);
  endtask

  task automatic t_pend();
    int s0 = n_sends;
    int r0 = rdcnt[BW];
    set_desc(0, OWN, EOR | FS | LS | 32'd80, 32'hD000_0000);
    do_poll();
    while (!snd_req) @(negedge clk);
    poll = 1'b1;
    @(negedge clk) poll = 1'b0;
    wait_quiet();
    chk_eq("R10", "poll during send rereads", rdcnt[BW] - r0, 3);
    chk_eq("R10", "single send", n_sends - s0, 1);
  endtask

  task automatic t_same();
    int s0 = n_sends;
    int r0 = rdcnt[BW];
    mem[BW] = 32'h0;
    do_poll();
    while (!(dm_ack && !dm_we)) @(negedge clk);
    poll = 1'b1;
    @(negedge clk) poll = 1'b0;
    wait_quiet();
    chk_eq("R10", "poll coinciding with stop rereads", rdcnt[BW] - r0, 2);
    chk_eq("R10", "no send on software status", n_sends - s0, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = '0;
      rdcnt[i] = 0;
    end
    n_sends = 0; n_done = 0; wb_ok = 0; order_bad = 0; first_rd_addr = -1;
    poll = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_single();
    t_chain();
    t_err();
    t_stop();
    t_pend();
    t_same();
    finish_run();
  end
endmodule